// File: doc/BRIEF.md
# Dual-Mode Serial Result Port

This block sits between a converter's digital filter and the pins. It sends a 20-bit result out serially, most significant bit first. The filter hands over each new result with a one-cycle load strobe. The block keeps that result until a host reads it. An active-low ready flag tells the host when an unread result is waiting. A falling edge on the active-low chip select starts a read.

Two clocking modes exist, chosen by `mode_self`. In the self-clocked mode the block drives the serial clock itself, at one quarter of the master clock, high for one master cycle in four. In the externally clocked mode the host drives the serial clock. That clock is synchronized with two flops, and the data advances on each synchronized falling edge. Each output pin comes with an enable, so the pad can go to high impedance.

Whenever a new result arrives, the ready flag goes high for a fixed four-cycle window. A chip select that falls inside that window is not seen. A result that arrives during a read waits in a shadow register, so the word being shifted is never corrupted. A read that the host cuts short finishes the bit in flight before the pins are released.

Top module: `ser_result_port`

## Requirements
- R1: After reset, `rdy_n` is 1 and `sdata_oe`, `sclk_oe` and `sclk_o` are 0.
- R2: A read presents the 20-bit word on `sdata_o` with bit 19 first and bit 0 last.
- R3: With `mode_self`=1, during a read `sclk_oe` is 1 and `sclk_o` is high for exactly one master cycle out of every four. `sclk_oe` is 0 outside a self-clocked read.
- R4: With `mode_self`=0, `sdata_o` moves to the next bit only after a falling edge of `sclk_in`, and `sclk_oe` stays 0.
- R5: `rdy_n` is 0 while an unread word is held and no reload window is open. It is 1 once a read has ended, until the next word is copied in.
- R6: Each `load_stb` pulse drives `rdy_n` to 1 for exactly four master cycles, even when a read is in progress.
- R7: A falling edge of `cs_n` inside the four-cycle reload window starts no read. Only a later falling edge of `cs_n` starts one.
- R8: When `cs_n` rises before all 20 bits have been sent, the bit in flight completes at the next serial-clock falling edge. The pins are then released and the word counts as read.
- R9: `sdata_oe` is 0 whenever no read is in progress.
- R10: A word loaded during a read does not alter the bits of that read. It becomes the word sent by the next read.
- R11: A falling edge of `cs_n` while no unread word is held starts no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_self | input | 1 | 1 = self-clocked, 0 = external serial clock |
| cs_n | input | 1 | Active-low chip select; a falling edge starts a read |
| load_stb | input | 1 | One-cycle strobe: a new word is present on `load_word` |
| load_word | input | WORD_W | New conversion result |
| sclk_in | input | 1 | External serial clock (externally clocked mode) |
| rdy_n | output | 1 | Active-low: an unread word is available |
| sdata_o | output | 1 | Serial data |
| sdata_oe | output | 1 | Drive enable for `sdata_o` |
| sclk_o | output | 1 | Generated serial clock (self-clocked mode) |
| sclk_oe | output | 1 | Drive enable for `sclk_o` |

## Verification
The bench has a receiver for each mode. Words are read through a walking-one sweep over all 20 positions, which exposes any slip in bit order or bit count. Solid-ones, solid-zeros and alternating words are read in both modes, which separates a stuck data line from a mistimed shift. Reads cut short after a few bits show whether the bit in flight completes and whether the pins are released. A reload placed mid-read and a chip select placed inside the reload window exercise the ready pulse, the shadow register and the ignored select.

// File: rtl/ser_result_port.sv
module ser_result_port #(
  parameter int WORD_W     = 20,
  parameter int RELOAD_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_self,
  input  logic              cs_n,
  input  logic              load_stb,
  input  logic [WORD_W-1:0] load_word,
  input  logic              sclk_in,
  output logic              rdy_n,
  output logic              sdata_o,
  output logic              sdata_oe,
  output logic              sclk_o,
  output logic              sclk_oe
);
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int HOLD_W = $clog2(RELOAD_CYC + 1);

  logic              cs_q, pend, valid, active, stop;
  logic [2:0]        sck_s;
  logic [1:0]        phase;
  logic [HOLD_W-1:0] hold;
  logic [CNT_W-1:0]  left;
  logic [WORD_W-1:0] shadow, sh;

  wire cs_fall  = cs_q & ~cs_n;
  wire ext_fall = sck_s[2] & ~sck_s[1];
  wire fall_ev  = active & (mode_self ? (phase == 2'd1) : ext_fall);
  wire start    = cs_fall & (hold == '0) & valid & ~active & ~pend;
  wire last_bit = (left == CNT_W'(1)) | stop | cs_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      sck_s  <= '0;
      hold   <= '0;
      shadow <= '0;
      sh     <= '0;
      pend   <= 1'b0;
      valid  <= 1'b0;
      active <= 1'b0;
      stop   <= 1'b0;
      phase  <= '0;
      left   <= '0;
    end else begin
      cs_q  <= cs_n;
      sck_s <= {sck_s[1:0], sclk_in};

      if (load_stb)          hold <= HOLD_W'(RELOAD_CYC);
      else if (hold != '0)   hold <= hold - 1'b1;

      if (load_stb) begin
        shadow <= load_word;
        pend   <= 1'b1;
      end else if (pend && !active) begin
        sh    <= shadow;
        pend  <= 1'b0;
        valid <= 1'b1;
      end

      if (start) begin
        active <= 1'b1;
        stop   <= 1'b0;
        phase  <= '0;
        left   <= CNT_W'(WORD_W);
      end else if (active) begin
        phase <= phase + 1'b1;
        if (cs_n) stop <= 1'b1;
        if (fall_ev) begin
          if (last_bit) begin
            active <= 1'b0;
            valid  <= 1'b0;
          end else begin
            sh   <= {sh[WORD_W-2:0], 1'b0};
            left <= left - 1'b1;
          end
        end
      end
    end
  end

  assign rdy_n    = ~valid | (hold != '0);
  assign sdata_o  = sh[WORD_W-1];
  assign sdata_oe = active;
  assign sclk_oe  = active & mode_self;
  assign sclk_o   = active & mode_self & (phase == 2'd1);

  p_reload_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> rdy_n);
  p_no_start_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdata_oe) |-> $past(hold == '0));
  p_duty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |=> !sclk_o);
  p_sclk_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> (sclk_oe && sdata_oe));
  p_shift_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !fall_ev) |=> $stable(sh));
  p_end_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdata_oe) |-> rdy_n);
endmodule

// File: tb/ser_result_port_tb.sv
module ser_result_port_tb_top;
  localparam int W = 20;

  logic clk = 1'b0, rst_n = 1'b0, mode_self = 1'b1, cs_n = 1'b1, load_stb = 1'b0, sclk_in = 1'b0;
  logic [W-1:0] load_word = '0;
  logic rdy_n, sdata_o, sdata_oe, sclk_o, sclk_oe;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  ser_result_port #(.WORD_W(W), .RELOAD_CYC(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_self(mode_self), .cs_n(cs_n),
    .load_stb(load_stb), .load_word(load_word), .sclk_in(sclk_in),
    .rdy_n(rdy_n), .sdata_o(sdata_o), .sdata_oe(sdata_oe),
    .sclk_o(sclk_o), .sclk_oe(sclk_oe));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(input logic [W-1:0] w);
    int hi = 0;
    @(negedge clk); load_stb = 1'b1; load_word = w;
    @(negedge clk); load_stb = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (rdy_n) hi++;
      @(negedge clk);
    end
    chk(hi == 4, "R6 reload pulse length", hi, 4);
    chk(rdy_n == 1'b0, "R5 ready after load", rdy_n, 0);
  endtask

  task automatic self_read(input logic [W-1:0] w, input int n_stop,
                           input bit mid_ld, input logic [W-1:0] w2);
    logic [W-1:0] got = '0;
    int n = 0, cyc = 0, last_hi = -1, rhi = 0;
    bit gap_bad = 0, started = 0, oe_bad = 0;
    int nexp = (n_stop == 0) ? W : n_stop;
    mode_self = 1'b1;
    @(negedge clk); cs_n = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); cyc++;
      if (load_stb) load_stb = 1'b0;
      if (sdata_oe) started = 1;
      if (started && !sdata_oe) break;
      if (sdata_oe && !sclk_oe) oe_bad = 1;
      if (rdy_n) rhi++;
      if (sclk_o) begin
        if (last_hi >= 0 && cyc - last_hi != 4) gap_bad = 1;
        last_hi = cyc;
        got = {got[W-2:0], sdata_o};
        n++;
        if (mid_ld && n == 8) begin load_stb = 1'b1; load_word = w2; end
        if (n_stop != 0 && n == n_stop) cs_n = 1'b1;
      end
    end
    chk(n == nexp, "R2/R8 bit count self", n, nexp);
    chk(got == (w >> (W - nexp)), "R2/R10 self data", got, w >> (W - nexp));
    chk(!gap_bad && !oe_bad, "R3 sclk period/enable", gap_bad, 0);
    if (mid_ld) chk(rhi == 4, "R6 pulse during read", rhi, 4);
    chk(rdy_n == 1'b1, "R5 ready high after read", rdy_n, 1);
    chk(!sdata_oe && !sclk_oe, "R9/R3 released", {sdata_oe, sclk_oe}, 0);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ext_read(input logic [W-1:0] w, input int n_stop);
    logic [W-1:0] got = '0;
    bit sck_bad = 0;
    int nexp = (n_stop == 0) ? W : n_stop;
    mode_self = 1'b0;
    @(negedge clk); cs_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sdata_oe == 1'b1, "R4 ext read started", sdata_oe, 1);
    for (int i = 0; i < nexp; i++) begin
      sclk_in = 1'b1;
      repeat (3) @(negedge clk);
      got = {got[W-2:0], sdata_o};
      if (sclk_oe) sck_bad = 1;
      if (i == nexp - 1 && n_stop != 0) begin
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(sdata_oe == 1'b1, "R8 bit in flight held", sdata_oe, 1);
      end
      sclk_in = 1'b0;
      repeat (5) @(negedge clk);
    end
    chk(got == (w >> (W - nexp)), "R2/R4 ext data", got, w >> (W - nexp));
    chk(!sck_bad, "R4 sclk_oe low in ext mode", sck_bad, 0);
    chk(sdata_oe == 1'b0, "R8/R9 ext released", sdata_oe, 0);
    chk(rdy_n == 1'b1, "R5 ready high after ext read", rdy_n, 1);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pats [4];
    pats[0] = '1; pats[1] = '0; pats[2] = 20'hA5A5A; pats[3] = 20'h5A5A5;
    repeat (3) @(negedge clk);
    chk(rdy_n && !sdata_oe && !sclk_oe && !sclk_o, "R1 reset state",
        {rdy_n, sdata_oe, sclk_oe, sclk_o}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: no word held
    cs_n = 1'b0; repeat (8) @(negedge clk);
    chk(sdata_oe == 1'b0, "R11 select without word", sdata_oe, 0);
    cs_n = 1'b1; @(negedge clk);
    // R2 R3 walking one, self-clocked
    for (int b = 0; b < W; b++) begin
      load(W'(1) << b);
      self_read(W'(1) << b, 0, 1'b0, '0);
    end
    // R4 patterns, both modes
    for (int p = 0; p < 4; p++) begin
      load(pats[p]); self_read(pats[p], 0, 1'b0, '0);
      load(pats[p]); ext_read(pats[p], 0);
    end
    for (int b = 0; b < W; b += 4) begin
      load(W'(3) << b); ext_read(W'(3) << b, 0);
    end
    // R11 after a completed read
    cs_n = 1'b0; repeat (8) @(negedge clk);
    chk(sdata_oe == 1'b0, "R11 select after read", sdata_oe, 0);
    cs_n = 1'b1; @(negedge clk);
    // R7 select inside reload window
    mode_self = 1'b1;
    load_stb = 1'b1; load_word = 20'h3C3C3;
    @(negedge clk); load_stb = 1'b0; cs_n = 1'b0;
    repeat (10) @(negedge clk);
    chk(sdata_oe == 1'b0, "R7 select in window ignored", sdata_oe, 0);
    chk(rdy_n == 1'b0, "R7/R5 word still unread", rdy_n, 0);
    cs_n = 1'b1; @(negedge clk);
    self_read(20'h3C3C3, 0, 1'b0, '0);
    // R8 cut-short reads
    load(20'hDEADB); self_read(20'hDEADB, 5, 1'b0, '0);
    chk(rdy_n == 1'b1, "R8 aborted word consumed", rdy_n, 1);
    load(20'h9C3E1); ext_read(20'h9C3E1, 7);
    // R10 reload during a read
    load(20'h12345);
    self_read(20'h12345, 0, 1'b1, 20'hFEDCB);
    repeat (2) @(negedge clk);
    chk(rdy_n == 1'b0, "R10 shadow word ready", rdy_n, 0);
    self_read(20'hFEDCB, 0, 1'b0, '0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule